// File: doc/BRIEF.md
# Self-Test Loop Progress Flag

This block runs the transmit-side self-test sequence and reports how far it has got on a status flag. A 9-bit linear feedback shift register advances once per character period while self-test is enabled. When the register sits in its fixed loop-start state on a character period, the block pulses `loop_start`. The encoder downstream uses that pulse to send the start character, and the block counts it as one completed pass through the loop. The register's current value is brought out on `pattern` as the test sequence.

Each pass becomes a flag event. Two modes are available:

- **Buffered mode** (`fifo_bypass` low): the event is held internally until the host addresses the device and sees the flag.
- **Bypass mode** (`fifo_bypass` high): the flag is a live one-clock pulse and keeps no history.

The flag leaves the block as a pin level that has already been put into the selected polarity (`cascade_mode` high gives active high, low gives active low). A separate output enable, `flag_oe`, follows the sampled address match, so an outer pad can tri-state the flag. The clock into the block is whichever interface clock the chosen mode uses. The mode inputs are assumed to stay fixed while self-test runs.

Top module: `bist_loop_flag`

## Requirements
- R1: After reset, `flag_oe` is low and the flag is inactive: `flag_out` is 0 with `cascade_mode`=1 and 1 with `cascade_mode`=0.
- R2: The flag is active high when `cascade_mode`=1 and active low when `cascade_mode`=0.
- R3: `flag_oe` equals the value `addr_match` had at the previous rising clock edge.
- R4: On the first clock at which `bist_en` is seen high after being low, the internal flag is cleared, whatever `addr_match` is.
- R5: While enabled, `pattern` advances on each clock with `char_tick` high. The next value is {p[7:0], p[8]^p[4]} (polynomial x^9+x^5+1). With `char_tick` low, `pattern` holds. `pattern` is never all-zero. Reset loads 9'h0F0.
- R6: `loop_start` is high in a cycle where self-test is enabled (as registered at the previous edge), `char_tick` is high and `pattern` equals the loop-start state 9'h1FF. While the block stays enabled with `char_tick` high every cycle, consecutive passes are exactly 511 cycles apart.
- R7: The first pass after enabling comes after exactly as many character ticks as the sequence needs to go from the reset state to the loop-start state.
- R8: In buffered mode, a pass sets the flag from the next clock onward. The flag stays set until it is observed. Several passes with no observation in between show up as a single indication.
- R9: The flag counts as observed in any cycle where `flag_oe` is high and the flag is set. It then clears at the next edge, unless a new pass happens in that same cycle, in which case it stays set.
- R10: In bypass mode, each pass makes the flag active for exactly the one clock after it. If `flag_oe` is low during that clock, the event is lost.
- R11: With `bist_en` low, `pattern` holds and `loop_start` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock for the selected mode |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en | input | 1 | Self-test enable, active high |
| char_tick | input | 1 | One character period has elapsed |
| addr_match | input | 1 | Host is addressing this device |
| cascade_mode | input | 1 | 1: flag active high; 0: flag active low |
| fifo_bypass | input | 1 | 1: live flag pulse; 0: held flag |
| loop_start | output | 1 | Pass marker; encoder sends the start character |
| pattern | output | 9 | Current LFSR test sequence value |
| flag_out | output | 1 | Flag pin level after polarity |
| flag_oe | output | 1 | Flag output enable |

## Verification
The loop is first run with the host addressing the device on every clock. This shows the one-clock flag pulse, and it confirms the short first pass and the 511-cycle repeat.

Holding the address off across two passes and then addressing once separates a held flag that merges events from one that counts them or loses them. Turning the address on in the exact cycle of a new pass checks that the set takes priority over the clear.

The same address-off pattern in bypass mode must lose the event. Re-enabling with a held flag pending shows the clear on enable. Runs with ticks suppressed and with self-test disabled separate stepping from holding.

// File: rtl/bist_flag_pkg.sv
package bist_flag_pkg;

  // Converts an internal asserted level to the pin level of the chosen polarity.
  function automatic logic pin_level(input logic asserted, input logic active_high);
    return active_high ? asserted : ~asserted;
  endfunction

  // The host has seen the flag when it is addressed while the flag is set.
  function automatic logic host_saw(input logic sampled_am, input logic flag_set);
    return sampled_am & flag_set;
  endfunction

  // Held-flag update: an enable edge clears it, a pass sets it,
  // and an observation clears it only when no pass coincides.
  function automatic logic held_next(input logic cur, input logic pass,
                                     input logic seen, input logic clr);
    if (clr)  return 1'b0;
    if (pass) return 1'b1;
    if (seen) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int          W        = 9,
  parameter logic [W-1:0] TAP_MASK = 9'h110,
  parameter logic [W-1:0] SEED     = 9'h1FF,
  parameter logic [W-1:0] INIT     = 9'h0F0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state,
  output logic         at_seed
);

  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAP_MASK)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= INIT;
    else if (step) state <= advance(state);
  end

  assign at_seed = (state == SEED);

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);                                               // R5
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));                                  // R5

endmodule

// File: rtl/bist_pass_gen.sv
module bist_pass_gen #(
  parameter int W = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bist_en,
  input  logic char_tick,
  input  logic at_seed,
  output logic en_q,
  output logic en_rise,
  output logic step,
  output logic pass_evt
);

  localparam int PERIOD = (1 << W) - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= bist_en;
  end

  assign en_rise  = bist_en & ~en_q;
  assign step     = en_q & char_tick;
  assign pass_evt = step & at_seed;

  // Independent check of the loop length: count steps between passes.
  logic [W-1:0] since_pass;
  logic         armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pass <= '0;
      armed      <= 1'b0;
    end else if (step) begin
      if (pass_evt) begin
        since_pass <= '0;
        armed      <= 1'b1;
      end else begin
        since_pass <= since_pass + 1'b1;
      end
    end
  end

  AST_LOOP_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_evt && armed) |-> since_pass == W'(PERIOD - 1));      // R6
  AST_IDLE_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !pass_evt);                                       // R11

endmodule

// File: rtl/bist_flag_hold.sv
module bist_flag_hold
  import bist_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bypass,
  input  logic en_rise,
  input  logic pass_evt,
  input  logic am_q,
  output logic flag_int,
  output logic seen
);

  logic held;
  logic live;

  assign seen     = host_saw(am_q, held) & ~bypass;
  assign flag_int = bypass ? live : held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      live <= 1'b0;
    end else begin
      held <= held_next(held, pass_evt, seen, en_rise);
      live <= pass_evt & ~en_rise;
    end
  end

  AST_CLEAR_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_rise |=> !flag_int);                                     // R4
  AST_HELD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !seen && !en_rise) |=> held);                      // R8
  AST_SEEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !pass_evt && !en_rise) |=> !held);                 // R9
  AST_PASS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pass_evt) |=> held);                               // R9
  AST_LIVE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && !pass_evt) |=> (!bypass || !flag_int));          // R10

endmodule

// File: rtl/bist_flag_drive.sv
module bist_flag_drive
  import bist_flag_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic addr_match,
  input  logic active_high,
  input  logic flag_int,
  output logic am_q,
  output logic flag_out,
  output logic flag_oe
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) am_q <= 1'b0;
    else        am_q <= addr_match;
  end

  assign flag_oe  = am_q;
  assign flag_out = pin_level(flag_int, active_high);

  AST_OE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    addr_match |=> flag_oe);                                    // R3
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_match |=> !flag_oe);                                  // R3

endmodule

// File: rtl/bist_loop_flag.sv
module bist_loop_flag #(
  parameter int           W        = 9,
  parameter logic [W-1:0] TAP_MASK = 9'h110,
  parameter logic [W-1:0] SEED     = 9'h1FF,
  parameter logic [W-1:0] INIT     = 9'h0F0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bist_en,
  input  logic         char_tick,
  input  logic         addr_match,
  input  logic         cascade_mode,
  input  logic         fifo_bypass,
  output logic         loop_start,
  output logic [W-1:0] pattern,
  output logic         flag_out,
  output logic         flag_oe
);

  logic at_seed;
  logic en_q;
  logic en_rise;
  logic step;
  logic pass_evt;
  logic am_q;
  logic flag_int;
  logic seen;

  bist_lfsr #(.W(W), .TAP_MASK(TAP_MASK), .SEED(SEED), .INIT(INIT)) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .state   (pattern),
    .at_seed (at_seed)
  );

  bist_pass_gen #(.W(W)) u_pass (
    .clk       (clk),
    .rst_n     (rst_n),
    .bist_en   (bist_en),
    .char_tick (char_tick),
    .at_seed   (at_seed),
    .en_q      (en_q),
    .en_rise   (en_rise),
    .step      (step),
    .pass_evt  (pass_evt)
  );

  bist_flag_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .bypass   (fifo_bypass),
    .en_rise  (en_rise),
    .pass_evt (pass_evt),
    .am_q     (am_q),
    .flag_int (flag_int),
    .seen     (seen)
  );

  bist_flag_drive u_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_match  (addr_match),
    .active_high (cascade_mode),
    .flag_int    (flag_int),
    .am_q        (am_q),
    .flag_out    (flag_out),
    .flag_oe     (flag_oe)
  );

  assign loop_start = pass_evt;

  AST_PASS_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    pass_evt |=> flag_int);                                     // R8
  AST_DISABLED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q) |=> $stable(pattern));                              // R11

endmodule

// File: tb/sim_bist_loop_flag.sv
`timescale 1ns/1ps
module sim_bist_loop_flag;

  localparam logic [8:0] SEED = 9'h1FF;
  localparam logic [8:0] INIT = 9'h0F0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bist_en = 1'b0, char_tick = 1'b1, addr_match = 1'b0;
  logic       cascade_mode = 1'b1, fifo_bypass = 1'b0;
  logic       loop_start, flag_out, flag_oe;
  logic [8:0] pattern;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bist_loop_flag #(.W(9), .TAP_MASK(9'h110), .SEED(SEED), .INIT(INIT)) u0 (
    .clk(clk), .rst_n(rst_n), .bist_en(bist_en), .char_tick(char_tick),
    .addr_match(addr_match), .cascade_mode(cascade_mode), .fifo_bypass(fifo_bypass),
    .loop_start(loop_start), .pattern(pattern), .flag_out(flag_out), .flag_oe(flag_oe)
  );

  // Sequence model written from R5: shift left, new bit is bit 8 xor bit 4.
  function automatic logic [8:0] ref_step(input logic [8:0] s);
    logic fb;
    fb = s[8] ^ s[4];
    return {s[7:0], fb};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Advance one clock; inputs change and outputs are read 1 ns after the edge.
  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  function automatic int lvl(input bit active);
    return cascade_mode ? int'(active) : int'(!active);
  endfunction

  task automatic run_until_pass(output int n);
    n = 0;
    while (!loop_start && n < 2000) begin
      cyc();
      n++;
    end
  endtask

  task automatic t_reset();
    cascade_mode = 1'b1; #1;
    chk(flag_out == 1'b0, "R1 idle level high-active", flag_out, 0);
    chk(flag_oe == 1'b0, "R1 oe after reset", flag_oe, 0);
    chk(pattern == INIT, "R5 reset state", pattern, INIT);
    cascade_mode = 1'b0; #1;
    chk(flag_out == 1'b1, "R1 R2 idle level low-active", flag_out, 1);
    cascade_mode = 1'b1; #1;
  endtask

  task automatic t_stepping();
    logic [8:0] prev;
    char_tick = 1'b1;
    for (int i = 0; i < 40; i++) cyc();
    chk(pattern == INIT, "R11 disabled holds", pattern, INIT);
    bist_en = 1'b1; char_tick = 1'b0;
    cyc();
    prev = pattern;
    for (int i = 0; i < 5; i++) cyc();
    chk(pattern == prev, "R5 no tick holds", pattern, prev);
    char_tick = 1'b1;
    for (int i = 0; i < 3; i++) begin
      prev = pattern;
      cyc();
      chk(pattern == ref_step(prev), "R5 step value", pattern, ref_step(prev));
    end
  endtask

  task automatic t_first_pass();
    int d, n;
    logic [8:0] s;
    rst_n = 1'b0; bist_en = 1'b0; addr_match = 1'b1; cascade_mode = 1'b1;
    fifo_bypass = 1'b0; char_tick = 1'b1;
    cyc(); rst_n = 1'b1;
    d = 0; s = INIT;
    while (s != SEED) begin s = ref_step(s); d++; end
    bist_en = 1'b1;
    cyc();
    run_until_pass(n);
    chk(n == d, "R7 first pass distance", n, d);
    chk(pattern == SEED, "R6 loop-start state", pattern, SEED);
    cyc();
    chk(flag_oe == 1'b1, "R3 oe follows match", flag_oe, 1);
    chk(flag_out == 1'b1, "R8 flag set after pass", flag_out, 1);
    cyc();
    chk(flag_out == 1'b0, "R9 observed flag clears", flag_out, 0);
    run_until_pass(n);
    chk(n + 2 == 511, "R6 loop period", n + 2, 511);
  endtask

  task automatic t_merge();
    int n;
    cascade_mode = 1'b0;
    addr_match = 1'b0;
    cyc();
    chk(flag_oe == 1'b0, "R3 oe low without match", flag_oe, 0);
    run_until_pass(n);
    cyc();
    run_until_pass(n);
    cyc();
    for (int i = 0; i < 4; i++) cyc();
    addr_match = 1'b1;
    cyc();
    chk(flag_oe == 1'b1, "R3 oe rises", flag_oe, 1);
    chk(flag_out == 1'b0, "R2 R8 held flag active-low", flag_out, 0);
    cyc();
    chk(flag_out == 1'b1, "R8 merged passes give one indication", flag_out, 1);
    cascade_mode = 1'b1; #1;
  endtask

  task automatic t_coincide();
    int n;
    addr_match = 1'b0;
    run_until_pass(n);
    cyc();
    for (int i = 0; i < 509; i++) cyc();
    addr_match = 1'b1;
    cyc();
    chk(loop_start == 1'b1, "R6 predicted pass cycle", loop_start, 1);
    chk(flag_out == 1'b1 && flag_oe == 1'b1, "R9 flag shown at pass", flag_out, 1);
    cyc();
    chk(flag_out == 1'b1, "R9 pass wins over clear", flag_out, 1);
    cyc();
    chk(flag_out == 1'b0, "R9 clears after later observation", flag_out, 0);
  endtask

  task automatic t_enable_clear();
    int n;
    logic [8:0] held;
    bit any;
    addr_match = 1'b0;
    run_until_pass(n);
    cyc();
    bist_en = 1'b0;
    cyc();
    held = pattern; any = 1'b0;
    for (int i = 0; i < 600; i++) begin
      cyc();
      if (loop_start) any = 1'b1;
    end
    chk(!any, "R11 no pass while disabled", any, 0);
    chk(pattern == held, "R11 pattern held while disabled", pattern, held);
    bist_en = 1'b1;
    cyc();
    addr_match = 1'b1;
    cyc();
    chk(flag_oe == 1'b1, "R3 oe on", flag_oe, 1);
    chk(flag_out == 1'b0, "R4 enable edge cleared flag", flag_out, 0);
  endtask

  task automatic t_bypass();
    int n;
    fifo_bypass = 1'b1; addr_match = 1'b1;
    run_until_pass(n);
    cyc();
    chk(flag_out == 1'b1 && flag_oe == 1'b1, "R10 live pulse", flag_out, 1);
    cyc();
    chk(flag_out == 1'b0, "R10 pulse lasts one clock", flag_out, 0);
    addr_match = 1'b0;
    run_until_pass(n);
    cyc();
    chk(flag_oe == 1'b0, "R10 not addressed at event", flag_oe, 0);
    addr_match = 1'b1;
    cyc();
    chk(flag_out == 1'b0, "R10 event lost", flag_out, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #12;
    t_reset();
    cyc(); rst_n = 1'b1; cyc();
    t_reset();
    t_stepping();
    t_first_pass();
    t_merge();
    t_coincide();
    t_enable_clear();
    t_bypass();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule